// File: doc/BRIEF.md
# Masked Channel Change-Event Generator

This block watches a word of binary channel states, one bit per channel. Each time a new snapshot arrives it is compared against the last snapshot kept inside the block. Every channel that differs and is enabled produces one event on a valid/ready output stream. The event holds the channel number and whether the channel went high or low.

Events leave one per cycle at most, lowest channel number first. The input side stays closed (its ready is low) until the whole batch for the current snapshot has drained. The kept snapshot is then replaced by the new one in full, including the bits of channels that are masked off. Disabling a channel therefore drops that channel's transitions rather than deferring them. A zero word is kept after reset, so the first snapshot reports a rising event for every enabled channel that reads 1.

Top module: `chg_evt_gen`

## Requirements
- R1: After reset `evtValid` is 0 and `snapReady` is 1. The kept snapshot is all zeros, so the first accepted snapshot yields one rising event for each enabled bit that is 1.
- R2: A snapshot identical to the kept one, or one whose changed bits are all masked, produces no event. `snapReady` returns to 1 no more than two cycles after acceptance.
- R3: `enableMask` is sampled in the cycle the snapshot is accepted (`snapValid` and `snapReady` both 1). A channel whose mask bit is 0 produces no event.
- R4: `evtRising` is 1 when the channel's new bit is 1 and 0 when it is 0.
- R5: Events from one snapshot leave in strictly ascending channel index order.
- R6: Once a snapshot's events are all delivered, the kept snapshot equals the whole new snapshot, masked bits included. A masked transition is never reported later.
- R7: `snapReady` is 0 from the cycle after acceptance until every event of that snapshot has been handed off.
- R8: An event is handed off when `evtValid` and `evtReady` are both 1 at a clock edge. While `evtValid` is 1 and `evtReady` is 0, `evtValid`, `evtChan` and `evtRising` hold.
- R9: Each enabled changed channel is reported exactly once per snapshot, and at most one event is handed off per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snapValid | input | 1 | New snapshot offered |
| snapReady | output | 1 | Block can take a snapshot |
| snapData | input | CH (32) | Channel states, bit i is channel i |
| enableMask | input | CH (32) | Per-channel event enable, 1 = enabled |
| evtValid | output | 1 | Event present |
| evtReady | input | 1 | Consumer takes the event |
| evtChan | output | IDXW (5) | Channel index of the event |
| evtRising | output | 1 | 1 = channel went high, 0 = went low |

## Verification
The assertions assume that the consumer may hold `evtReady` low for any length of time. They also assume that `snapData` and `enableMask` matter only in the acceptance cycle, so they say nothing about these inputs outside it. The stimulus offers a snapshot only while `snapReady` is high and drops `snapValid` right after the edge that accepts it. It drives `evtReady` either constantly high or toggling every cycle, which exercises the hold rule between handoffs. The ordering property compares consecutive handoffs within one batch. It depends on the idle cycle that separates batches, which the stimulus never bypasses.

// File: rtl/chg_evt_pkg.sv
package chg_evt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture snapshot, build pending set
    logic pop;     // current event handed off, clear its bit
    logic commit;  // batch drained, replace kept snapshot
  } evtStrobe_t;
endpackage

// File: rtl/chg_evt_dp.sv
module chg_evt_dp
  import chg_evt_pkg::*;
#(
  parameter int CH   = 32,
  parameter int IDXW = $clog2(CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  evtStrobe_t      strobes,
  input  logic [CH-1:0]   snapData,
  input  logic [CH-1:0]   enableMask,
  input  logic            evtReady,
  output logic            pendingAny,
  output logic            evtValid,
  output logic [IDXW-1:0] evtChan,
  output logic            evtRising
);
  logic [CH-1:0]   keptSnap;
  logic [CH-1:0]   heldSnap;
  logic [CH-1:0]   pending;
  logic [IDXW-1:0] lowIdx;

  // lowest set bit of the pending set
  always_comb begin
    lowIdx = '0;
    for (int i = CH - 1; i >= 0; i--) begin
      if (pending[i]) lowIdx = IDXW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keptSnap <= '0;
      heldSnap <= '0;
      pending  <= '0;
    end else begin
      if (strobes.load) begin
        heldSnap <= snapData;
        pending  <= (keptSnap ^ snapData) & enableMask;
      end else if (strobes.pop) begin
        pending[lowIdx] <= 1'b0;
      end
      if (strobes.commit) keptSnap <= heldSnap;
    end
  end

  assign pendingAny = |pending;
  assign evtValid   = pendingAny;
  assign evtChan    = lowIdx;
  assign evtRising  = heldSnap[lowIdx];

  // R8: a stalled event holds its payload
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid && !evtReady |=> evtValid && $stable(evtChan) && $stable(evtRising));

  // R5: consecutive handoffs move to a higher channel
  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evtValid && evtReady) && evtValid |-> evtChan > $past(evtChan));

  // R9: a handed-off channel is not presented again
  p_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid && evtReady |=> !evtValid || (evtChan != $past(evtChan)));
endmodule

// File: rtl/chg_evt_ctrl.sv
module chg_evt_ctrl
  import chg_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       snapValid,
  input  logic       evtReady,
  input  logic       pendingAny,
  output logic       snapReady,
  output evtStrobe_t strobes
);
  typedef enum logic {ST_IDLE, ST_DRAIN} ctrlState_t;
  ctrlState_t state;

  assign snapReady      = (state == ST_IDLE);
  assign strobes.load   = snapReady && snapValid;
  assign strobes.pop    = (state == ST_DRAIN) && pendingAny && evtReady;
  assign strobes.commit = (state == ST_DRAIN) && !pendingAny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (strobes.load)   state <= ST_DRAIN;
        ST_DRAIN: if (strobes.commit) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R7: input stays closed while events are outstanding
  p_busy_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pendingAny |-> !snapReady);

  // R6: an empty batch commits and reopens the input next cycle
  p_drain_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !snapReady && !pendingAny |=> snapReady);
endmodule

// File: rtl/chg_evt_gen.sv
module chg_evt_gen
  import chg_evt_pkg::*;
#(
  parameter int CH   = 32,
  parameter int IDXW = $clog2(CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snapValid,
  output logic            snapReady,
  input  logic [CH-1:0]   snapData,
  input  logic [CH-1:0]   enableMask,
  output logic            evtValid,
  input  logic            evtReady,
  output logic [IDXW-1:0] evtChan,
  output logic            evtRising
);
  evtStrobe_t strobes;
  logic       pendingAny;

  chg_evt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .snapValid  (snapValid),
    .evtReady   (evtReady),
    .pendingAny (pendingAny),
    .snapReady  (snapReady),
    .strobes    (strobes)
  );

  chg_evt_dp #(.CH(CH), .IDXW(IDXW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .snapData   (snapData),
    .enableMask (enableMask),
    .evtReady   (evtReady),
    .pendingAny (pendingAny),
    .evtValid   (evtValid),
    .evtChan    (evtChan),
    .evtRising  (evtRising)
  );
endmodule

// File: tb/chg_evt_gen_tb.sv
`timescale 1ns/1ps
module chg_evt_gen_tb;
  localparam int CH = 32;
  localparam int IDXW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snapValid = 1'b0;
  logic snapReady;
  logic [CH-1:0] snapData = '0;
  logic [CH-1:0] enableMask = '1;
  logic evtValid;
  logic evtReady = 1'b1;
  logic [IDXW-1:0] evtChan;
  logic evtRising;

  int compared = 0;
  int mismatched = 0;
  logic [CH-1:0] modelKept = '0;

  always #4 clk = ~clk;

  chg_evt_gen #(.CH(CH), .IDXW(IDXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .snapValid(snapValid), .snapReady(snapReady),
    .snapData(snapData), .enableMask(enableMask), .evtValid(evtValid),
    .evtReady(evtReady), .evtChan(evtChan), .evtRising(evtRising)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // offer one snapshot, collect its events, compare with the model
  // stallMode 0: ready always high, 1: ready toggles each cycle
  task automatic run_snap(input logic [CH-1:0] snap, input logic [CH-1:0] mask,
                          input int stallMode, input string tag);
    int expChan[CH];
    bit expRise[CH];
    int expN = 0;
    int gotN = 0;
    int cyc = 0;
    int lastStallChan = -1;
    bit lastStallRise = 0;
    logic [CH-1:0] diff;
    diff = (modelKept ^ snap) & mask;
    for (int i = 0; i < CH; i++) begin
      if (diff[i]) begin
        expChan[expN] = i;
        expRise[expN] = snap[i];
        expN++;
      end
    end
    while (!snapReady) @(negedge clk);
    snapData = snap; enableMask = mask; snapValid = 1'b1;
    @(negedge clk);
    snapValid = 1'b0;
    enableMask = ~mask;  // changes after acceptance must not matter (R3)
    forever begin
      evtReady = (stallMode == 0) ? 1'b1 : cyc[0];
      #1;
      if (evtValid) check(!snapReady, {tag, " R7 closed"}, int'(snapReady), 0);
      if (lastStallChan >= 0) begin
        check(evtValid && int'(evtChan) == lastStallChan && evtRising == lastStallRise,
              {tag, " R8 hold"}, int'(evtChan), lastStallChan);
        lastStallChan = -1;
      end
      if (evtValid && evtReady) begin
        if (gotN < expN) begin
          check(int'(evtChan) == expChan[gotN], {tag, " R5 chan"}, int'(evtChan), expChan[gotN]);
          check(evtRising == expRise[gotN], {tag, " R4 dir"}, int'(evtRising), int'(expRise[gotN]));
        end
        gotN++;
      end else if (evtValid) begin
        lastStallChan = int'(evtChan);
        lastStallRise = evtRising;
      end
      if (snapReady && !evtValid) break;
      cyc++;
      @(negedge clk);
    end
    check(gotN == expN, {tag, " R9 count"}, gotN, expN);
    if (expN == 0) check(cyc <= 2, {tag, " R2 reopen"}, cyc, 2);
    modelKept = snap;
    evtReady = 1'b1;
  endtask

  task automatic t_reset();
    check(snapReady == 1'b1, "R1 snapReady", int'(snapReady), 1);
    check(evtValid == 1'b0, "R1 evtValid", int'(evtValid), 0);
  endtask

  task automatic t_first_snap();
    run_snap(32'h8000_00A5, '1, 0, "R1 first");
  endtask

  task automatic t_no_change();
    run_snap(32'h8000_00A5, '1, 0, "R2 same");
  endtask

  task automatic t_falling_mix();
    run_snap(32'h0F00_0021, '1, 0, "R4 mix");
  endtask

  task automatic t_masked();
    run_snap(32'hF0F0_F0F0, 32'h0000_FFFF, 0, "R3 mask");
  endtask

  task automatic t_masked_update();
    // same word, all enabled: masked flips were absorbed, nothing to report (R6)
    run_snap(32'hF0F0_F0F0, '1, 0, "R6 absorbed");
  endtask

  task automatic t_all_masked();
    run_snap(32'h0000_0000, 32'h0000_0000, 0, "R2 allmasked");
    run_snap(32'h0000_0000, '1, 0, "R6 after");
  endtask

  task automatic t_backpressure();
    run_snap(32'hDEAD_BEEF, '1, 1, "R8 stall");
  endtask

  task automatic t_all_toggle();
    run_snap(~32'hDEAD_BEEF, '1, 0, "R9 full");
    run_snap(32'hFFFF_FFFF, '1, 1, "R5 edge");
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_snap();
    t_no_change();
    t_falling_mix();
    t_masked();
    t_masked_update();
    t_all_masked();
    t_backpressure();
    t_all_toggle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule